// File: doc/BRIEF.md
# Receive Ring Fill Controller

This block takes a byte stream on a valid/ready handshake and stores it as whole messages in a word-wide circular buffer held in a synchronous SRAM. Bytes are packed into 32-bit words. Each stored message starts with one header word that gives its length in bytes, and the payload words follow it. The block keeps the write pointer and moves it only after a complete message has been stored. The reading side, usually driver software, keeps the read pointer and supplies it as an input.

Payload words are written into the slots after the pending write pointer while the message streams in. The header goes into the slot at the write pointer only after the last byte. The pointer then jumps past the whole message in one step, and a one-cycle interrupt pulse tells the reader that new data is waiting. A reader that polls the pointer therefore never sees a message that is only partly written. If the ring runs out of space during a message, the message is dropped without any notice. Its header is never written, the pointer stays where it was, and the producer keeps streaming without being stalled.

Top module: `rxring_filler`

## Requirements
- R1: `in_ready` is high at all times except for exactly one cycle: the cycle after the accepted final byte (`in_last` high) of a message that is kept. A byte transfers on a rising edge where `in_valid` and `in_ready` are both high.
- R2: Byte k of a message (counting from 0) is placed in payload word k/4 at bit position 8*(k mod 4), with the lowest byte first. Payload word i is written to address (wr_ptr + 1 + i) mod depth, in the same cycle as the byte that completes it.
- R3: In a final payload word that is only partly filled, the unused upper byte lanes are written as zero.
- R4: The header is written in the cycle after the final byte, after all payload words, at address wr_ptr. Bits 15:0 hold the payload length in bytes and bits 31:16 are zero.
- R5: wr_ptr holds its value except at the edge that ends the header cycle, where it advances by (payload words + 1) mod depth.
- R6: `irq` is high for exactly one cycle for each kept message, and it is high in the first cycle that shows the new wr_ptr. It is high at no other time.
- R7: Free space is depth − 1 − ((wr_ptr − rd_ptr) mod depth). A message is kept only if its payload words plus one header word fit in the free space. No write ever lands outside the free region.
- R8: A message that does not fit is dropped. No header is written at wr_ptr, wr_ptr does not move, `irq` stays low, and `in_ready` stays high for the whole message.
- R9: Messages of any length from 1 byte up are handled, including 4 to 16 bytes. Idle cycles between bytes of a message have no effect on what is stored.
- R10: During and right after reset, wr_ptr is 0, `irq` and `mem_we` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer has a byte on `in_data` |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a message |
| rd_ptr | input | ADDR_W | Word read pointer owned by the reader |
| wr_ptr | output | ADDR_W | Committed word write pointer |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM word address |
| mem_wdata | output | 8*WORD_BYTES | SRAM write data |
| irq | output | 1 | One-cycle pulse when wr_ptr moves |

## Verification
The assertions take for granted that rd_ptr only moves forward and never passes wr_ptr, because a reader that frees more than it consumed would void the free-space bound. They also assume the producer holds a byte steady until it is taken. The stimulus changes rd_ptr only between messages, sets it to values at or behind the committed pointer, and drives each byte until the cycle in which it is accepted. Its message lengths and read-pointer positions produce kept messages that wrap around the ring, messages that fill the ring exactly, drops with the ring completely full, and a drop where some payload words fit before space runs out.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // Controller phase: collecting payload bytes, or storing the header.
    typedef enum logic {
        ST_RECV = 1'b0,
        ST_HDR  = 1'b1
    } rxf_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/rxf_packer.sv
module rxf_packer #(
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              take,
    input  logic [rxf_pkg::BYTE_W-1:0]        byte_in,
    input  logic                              last,
    output logic [rxf_pkg::BYTE_W*WORD_BYTES-1:0] word_out,
    output logic                              word_done
);
    localparam int unsigned WORD_W = rxf_pkg::BYTE_W * WORD_BYTES;
    localparam int unsigned LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [LANE_W-1:0] lane;
    } pack_t;

    pack_t pk_d, pk_q;

    always_comb begin
        pk_d      = pk_q;
        word_out  = pk_q.acc | (WORD_W'(byte_in) << {pk_q.lane, 3'b000});
        word_done = take && (last || (pk_q.lane == LANE_W'(WORD_BYTES - 1)));
        if (take) begin
            if (word_done) begin
                pk_d = '0;
            end else begin
                pk_d.acc  = word_out;
                pk_d.lane = pk_q.lane + LANE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    // R3: lanes at and above the next fill position hold zero, so a short
    // final word leaves the block zero padded.
    a_r3_upper_lanes_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.acc >> {pk_q.lane, 3'b000}) == '0);

endmodule

// File: rtl/rxf_space.sv
module rxf_space #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] wptr,
    input  logic [ADDR_W-1:0] rptr,
    output logic [ADDR_W-1:0] free
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] used;

    // One slot always stays empty, so a full ring never looks like an empty one.
    always_comb begin
        used = wptr - rptr;
        free = ADDR_W'(DEPTH - 1) - used;
    end

endmodule

// File: rtl/rxring_filler.sv
module rxring_filler #(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    output logic                                  in_ready,
    input  logic [7:0]                            in_data,
    input  logic                                  in_last,
    input  logic [ADDR_W-1:0]                     rd_ptr,
    output logic [ADDR_W-1:0]                     wr_ptr,
    output logic                                  mem_we,
    output logic [ADDR_W-1:0]                     mem_addr,
    output logic [rxf_pkg::BYTE_W*WORD_BYTES-1:0] mem_wdata,
    output logic                                  irq
);
    import rxf_pkg::*;

    localparam int unsigned WORD_W = BYTE_W * WORD_BYTES;
    localparam int unsigned CNT_W  = LEN_W;

    typedef struct packed {
        rxf_state_e        state;
        logic [ADDR_W-1:0] wptr;
        logic [CNT_W-1:0]  nbytes;
        logic [CNT_W-1:0]  nwords;
        logic [LEN_W-1:0]  hdr_len;
        logic              drop;
        logic              irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              take;
    logic [WORD_W-1:0] pk_word;
    logic              pk_done;
    logic [ADDR_W-1:0] free_words;
    logic [CNT_W:0]    need;
    logic              fits;

    assign in_ready = (ctl_q.state == ST_RECV);
    assign take     = in_valid && in_ready;
    assign wr_ptr   = ctl_q.wptr;
    assign irq      = ctl_q.irq;

    rxf_packer #(.WORD_BYTES(WORD_BYTES)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .byte_in  (in_data),
        .last     (in_last),
        .word_out (pk_word),
        .word_done(pk_done)
    );

    rxf_space #(.ADDR_W(ADDR_W)) u_space (
        .wptr(ctl_q.wptr),
        .rptr(rd_ptr),
        .free(free_words)
    );

    // Words needed so far: the words already stored, this one, and the header.
    always_comb begin
        need = {1'b0, ctl_q.nwords} + (CNT_W + 1)'(2);
        fits = !ctl_q.drop && (need <= (CNT_W + 1)'(free_words));
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ctl_q.wptr + ADDR_W'(1) + ADDR_W'(ctl_q.nwords);
        mem_wdata = pk_word;
        unique case (ctl_q.state)
            ST_RECV: begin
                if (take) begin
                    ctl_d.nbytes = ctl_q.nbytes + CNT_W'(1);
                    if (pk_done) begin
                        if (fits) begin
                            mem_we       = 1'b1;
                            ctl_d.nwords = ctl_q.nwords + CNT_W'(1);
                        end else begin
                            ctl_d.drop = 1'b1;
                        end
                    end
                    if (in_last) begin
                        ctl_d.nbytes = '0;
                        if (fits) begin
                            ctl_d.state   = ST_HDR;
                            ctl_d.hdr_len = LEN_W'(ctl_q.nbytes + CNT_W'(1));
                        end else begin
                            ctl_d.nwords = '0;
                            ctl_d.drop   = 1'b0;
                        end
                    end
                end
            end
            ST_HDR: begin
                mem_we       = 1'b1;
                mem_addr     = ctl_q.wptr;
                mem_wdata    = {{(WORD_W - LEN_W){1'b0}}, ctl_q.hdr_len};
                ctl_d.wptr   = ctl_q.wptr + ADDR_W'(ctl_q.nwords) + ADDR_W'(1);
                ctl_d.irq    = 1'b1;
                ctl_d.nwords = '0;
                ctl_d.state  = ST_RECV;
            end
            default: ctl_d.state = ST_RECV;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    logic [ADDR_W-1:0] wr_offset;
    assign wr_offset = mem_addr - wr_ptr;

    // R1: the producer is held off only right after a kept message ends.
    a_r1_stall_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> $past(in_valid && in_ready && in_last));
    a_r1_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    // R2: payload writes only happen on an accepted byte.
    a_r2_write_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && in_ready) |-> take);

    // R4: the header goes to the committed pointer slot, upper half zero.
    a_r4_header_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !in_ready) |-> (mem_addr == wr_ptr && mem_wdata[WORD_W-1:LEN_W] == '0));

    // R5: the pointer moves only at the end of a header write.
    a_r5_move_after_header: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr != $past(wr_ptr)) |-> ($past(mem_we) && !$past(in_ready)));

    // R6: the interrupt marks exactly the cycles that show a new pointer.
    a_r6_irq_on_move: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (wr_ptr != $past(wr_ptr)));
    a_r6_move_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr != $past(wr_ptr)) |-> irq);
    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: nothing is written outside the free region.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_offset < free_words));

    // R8: a dropped message never stalls the producer.
    a_r8_drop_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_last && ctl_q.drop) |=> in_ready);

endmodule

// File: tb/sim_rxring_filler.sv
`timescale 1ns/100ps
module sim_rxring_filler;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 11;

    // Vector: [15:8] length, [7:4] rd_ptr, [3:1] idle cycles between bytes, [0] kept.
    localparam logic [15:0] VECS [NVEC] = '{
        16'h0401, 16'h0503, 16'h1001, 16'h0D05, 16'h0700, 16'h10A1,
        16'h0CA3, 16'h04A0, 16'h10D0, 16'h0981, 16'h0181
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic [AW-1:0] rd_ptr = '0;
    logic [AW-1:0] wr_ptr;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          irq;

    always #2.5 clk = ~clk;

    rxring_filler #(.ADDR_W(AW), .LEN_W(16), .WORD_BYTES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0]   model [DEPTH];
    int            irq_cnt;
    logic [AW-1:0] irq_ptr;
    logic [AW-1:0] watch_addr;
    int            watch_hits;

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            model[mem_addr] <= mem_wdata;
            if (mem_addr == watch_addr) watch_hits <= watch_hits + 1;
        end
        if (rst_n && irq) begin
            irq_cnt <= irq_cnt + 1;
            irq_ptr <= wr_ptr;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int id, input int k);
        return 8'(id * 16 + k + 1);
    endfunction

    task automatic send_msg(input int len, input int id, input int gap, output int waits);
        waits = 0;
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1;
            in_data  = byte_of(id, k);
            in_last  = (k == len - 1);
            @(negedge clk);
            while (!in_ready) begin
                waits++;
                @(negedge clk);
            end
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_last  = 1'b0;
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1;
            end
        end
    endtask

    task automatic check_body(input int len, input int id, input logic [AW-1:0] base, input string tag);
        int words;
        words = (len + 3) / 4;
        chk(model[base] == 32'(len), {tag, " R4 header"}, model[base], 32'(len));
        for (int w = 0; w < words; w++) begin
            logic [31:0] exp;
            exp = '0;
            for (int b = 0; b < 4; b++)
                if (4 * w + b < len) exp[8*b +: 8] = byte_of(id, 4 * w + b);
            chk(model[AW'(base + 1 + w)] == exp, {tag, " R2 R3 payload"}, model[AW'(base + 1 + w)], exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [AW-1:0] exp_ptr;
        int waits;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        irq_cnt = 0; irq_ptr = '0; watch_addr = '0; watch_hits = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(wr_ptr == 0, "R10 wr_ptr", 32'(wr_ptr), 0);
        chk(irq == 0 && mem_we == 0, "R10 irq/we", {30'd0, irq, mem_we}, 0);
        chk(in_ready == 1, "R10 in_ready", 32'(in_ready), 1);
        exp_ptr = '0;

        for (int v = 0; v < NVEC; v++) begin
            int len, gap, words;
            bit kept;
            logic [AW-1:0] old;
            len   = int'(VECS[v][15:8]);
            gap   = int'(VECS[v][3:1]);
            kept  = VECS[v][0];
            words = (len + 3) / 4;
            old   = exp_ptr;
            @(posedge clk); #1;
            rd_ptr = VECS[v][7:4];
            irq_cnt = 0; watch_hits = 0; watch_addr = old;
            send_msg(len, v, gap, waits);
            repeat (4) @(posedge clk);
            @(negedge clk);
            // R1 / R8 / R9: no stall while bytes of a message stream in
            chk(waits == 0, "R1 R8 R9 no stall inside message", 32'(waits), 0);
            if (kept) begin
                exp_ptr = AW'(old + words + 1);
                chk(wr_ptr == exp_ptr, "R5 R7 pointer advance", 32'(wr_ptr), 32'(exp_ptr));
                chk(irq_cnt == 1, "R6 irq once", 32'(irq_cnt), 1);
                chk(irq_ptr == exp_ptr, "R6 irq with new pointer", 32'(irq_ptr), 32'(exp_ptr));
                check_body(len, v, old, "R9");
            end else begin
                chk(wr_ptr == old, "R8 R7 pointer held on drop", 32'(wr_ptr), 32'(old));
                chk(irq_cnt == 0, "R8 no irq on drop", 32'(irq_cnt), 0);
                chk(watch_hits == 0, "R8 no header on drop", 32'(watch_hits), 0);
            end
        end

        // R1: back-to-back messages; the second waits exactly one header cycle
        begin
            logic [AW-1:0] p0, p1;
            int w0, w1;
            p0 = exp_ptr;
            p1 = AW'(p0 + 2);
            @(posedge clk); #1;
            rd_ptr = exp_ptr;
            irq_cnt = 0; watch_addr = '1; watch_hits = 0;
            send_msg(4, 12, 0, w0);
            send_msg(6, 13, 0, w1);
            repeat (4) @(posedge clk);
            @(negedge clk);
            chk(w1 == 1, "R1 stall after kept message", 32'(w1), 1);
            chk(irq_cnt == 2, "R6 two pulses", 32'(irq_cnt), 2);
            exp_ptr = AW'(p1 + 3);
            chk(wr_ptr == exp_ptr, "R5 back-to-back pointer", 32'(wr_ptr), 32'(exp_ptr));
            check_body(4, 12, p0, "R1");
            check_body(6, 13, p1, "R1");
        end

        summary();
        $finish;
    end
endmodule